// File: doc/BRIEF.md
# Vectored priority interrupt controller

This block collects eight level-sensitive device request lines and presents them to a CPU that takes vectored interrupts. Each cycle the request lines are sampled into a request register. A software mask filters them, and an in-service register holds off anything of equal or lower priority than an interrupt already being handled. When a request survives those filters, INTR is raised. The controller then waits for the CPU's acknowledge strobes.

The first acknowledge strobe commits to a winner and marks it in service. The last of three strobes places an 8-bit vector on the data bus. The vector is a programmed 5-bit base followed by the 3-bit pin number. Software ends the handling of an interrupt with an end-of-interrupt command. That command is either non-specific (it clears the most urgent in-service bit) or names a pin. Alternatively, an automatic mode clears the bit when the acknowledge finishes. Because the lines are level sensitive, a device that is still asserting its line after end-of-interrupt is served again.

Top module: `vpic_top`

## Requirements
- R1: After reset INTR is low, every pin is masked (address 1 reads 0xFF), automatic end-of-interrupt is off, and address 0 reads 0x00.
- R2: Pin 0 has the highest priority and pin 7 the lowest; the vector names the lowest-numbered eligible pin.
- R3: A write to address 1 loads the mask (bit n covers pin n) and reading address 1 returns it; a pin whose mask bit is 1 never raises INTR.
- R4: INTR goes high on the clock edge that samples an unmasked, unblocked request, and falls on the edge at which the request, seen through the mask, disappears.
- R5: An acknowledge consists of three cycles with inta_i high. vec_oe_o stays low in the first two. In the third it is high with the vector on vec_o.
- R6: The first acknowledge cycle sets the winner's in-service bit. While that bit is set, requests on that pin and on higher-numbered pins do not raise INTR, but lower-numbered pins still do.
- R7: Writing 0x40 to address 0 (non-specific end-of-interrupt) clears only the lowest-numbered in-service bit that is set.
- R8: Writing 0x80 | n to address 0 (specific end-of-interrupt) clears only the in-service bit of pin n.
- R9: Writing 0x01 to address 0 turns automatic end-of-interrupt on, and writing 0x00 turns it off. When it is on, the in-service bit is cleared at the edge that ends the third acknowledge cycle.
- R10: A request line still high when its in-service bit clears raises INTR again and yields the same vector.
- R11: If no eligible request exists at the first acknowledge cycle, the vector uses pin 7 and no in-service bit is set.
- R12: INTR stays low from the edge that closes the first acknowledge cycle until the sequence ends.
- R13: Writing 0xC0 | b (b 5 bits) to address 0 sets the vector base, so the vector is b * 8 + pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 8 | Level-sensitive device request lines, bit n is pin n |
| intr_o | output | 1 | Interrupt request to the CPU |
| inta_i | input | 1 | Acknowledge strobe, one cycle high per acknowledge cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address: 0 command, 1 mask |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (mask at address 1, zero at address 0) |
| vec_o | output | 8 | Vector byte |
| vec_oe_o | output | 1 | Vector bus drive enable (low means tri-stated) |

## Verification
A request line reaches intr_o through one register, so the bench drives it at a falling edge and samples INTR at the next falling edge. A mask write, an end-of-interrupt command, or the end of an acknowledge also acts on intr_o after exactly one edge. The vector enable is combinational on inta_i in the third acknowledge cycle, so it is sampled shortly after inta_i is driven, before the rising edge that closes that cycle. The sweeps cover every pin under two bases, all 255 non-empty request patterns, and all 256 mask values. Each expected vector and INTR level is derived arithmetically from the pattern.

// File: rtl/vpic_pkg.sv
`timescale 1ns/1ps
package vpic_pkg;
  // command opcode carried in the two top bits of a write to address 0
  typedef enum logic [1:0] {
    OP_MODE   = 2'b00,
    OP_EOI_NS = 2'b01,
    OP_EOI_SP = 2'b10,
    OP_BASE   = 2'b11
  } cmd_op_e;

  localparam int unsigned ACK_STROBES_DEF = 3;
endpackage

// File: rtl/vpic_regs.sv
`timescale 1ns/1ps
module vpic_regs
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned DATA_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [NUM_IRQ-1:0]            mask_q,
  output logic [DATA_W-$clog2(NUM_IRQ)-1:0] base_q,
  output logic                          aeoi_q,
  output logic                          eoi_ns,
  output logic                          eoi_sp,
  output logic [$clog2(NUM_IRQ)-1:0]    eoi_pin
);
  localparam int unsigned PIN_W  = $clog2(NUM_IRQ);
  localparam int unsigned BASE_W = DATA_W - PIN_W;

  cmd_op_e op;
  logic    cmd_wr;
  logic    mask_wr;
  logic    unused_bits;

  assign op          = cmd_op_e'(wdata[DATA_W-1 -: 2]);
  assign cmd_wr      = wr_en && !addr;
  assign mask_wr     = wr_en && addr;
  assign unused_bits = ^wdata;

  assign eoi_ns  = cmd_wr && (op == OP_EOI_NS);
  assign eoi_sp  = cmd_wr && (op == OP_EOI_SP);
  assign eoi_pin = wdata[PIN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      base_q <= '0;
      aeoi_q <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= wdata[NUM_IRQ-1:0];
      if (cmd_wr && op == OP_BASE) base_q <= wdata[BASE_W-1:0];
      if (cmd_wr && op == OP_MODE) aeoi_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr) rdata[NUM_IRQ-1:0] = mask_q;
  end
endmodule

// File: rtl/vpic_prio.sv
`timescale 1ns/1ps
module vpic_prio #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0]         irr,
  input  logic [NUM_IRQ-1:0]         mask,
  input  logic [NUM_IRQ-1:0]         isr,
  output logic [NUM_IRQ-1:0]         allow,
  output logic                       cand_valid,
  output logic [$clog2(NUM_IRQ)-1:0] cand_pin
);
  localparam int unsigned PIN_W = $clog2(NUM_IRQ);

  // pins strictly more urgent than the most urgent in-service pin
  function automatic logic [NUM_IRQ-1:0] above_service(input logic [NUM_IRQ-1:0] svc);
    logic [NUM_IRQ-1:0] m;
    logic               hit;
    m   = '0;
    hit = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (svc[i]) hit = 1'b1;
      if (!hit)   m[i] = 1'b1;
    end
    return m;
  endfunction

  // lowest-numbered set bit
  function automatic logic [PIN_W-1:0] first_pin(input logic [NUM_IRQ-1:0] v);
    logic [PIN_W-1:0] p;
    p = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (v[i]) p = PIN_W'(i);
    end
    return p;
  endfunction

  logic [NUM_IRQ-1:0] eligible;

  assign allow      = above_service(isr);
  assign eligible   = irr & ~mask & allow;
  assign cand_valid = |eligible;
  assign cand_pin   = first_pin(eligible);
endmodule

// File: rtl/vpic_ack.sv
`timescale 1ns/1ps
module vpic_ack #(
  parameter int unsigned NUM_IRQ     = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ACK_STROBES = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              inta,
  input  logic                              cand_valid,
  input  logic [$clog2(NUM_IRQ)-1:0]        cand_pin,
  input  logic [DATA_W-$clog2(NUM_IRQ)-1:0] base,
  input  logic                              aeoi,
  input  logic                              eoi_ns,
  input  logic                              eoi_sp,
  input  logic [$clog2(NUM_IRQ)-1:0]        eoi_pin,
  output logic [NUM_IRQ-1:0]                isr_q,
  output logic                              busy,
  output logic                              commit,
  output logic                              finish,
  output logic [DATA_W-1:0]                 vec,
  output logic                              vec_oe
);
  localparam int unsigned PIN_W  = $clog2(NUM_IRQ);
  localparam int unsigned BASE_W = DATA_W - PIN_W;
  localparam int unsigned CNT_W  = $clog2(ACK_STROBES) + 1;
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(ACK_STROBES - 1);
  localparam logic [PIN_W-1:0] SPUR_PIN = PIN_W'(NUM_IRQ - 1);

  function automatic logic [DATA_W-1:0] make_vector(input logic [BASE_W-1:0] b,
                                                    input logic [PIN_W-1:0]  p);
    return {b, p};
  endfunction

  function automatic logic [NUM_IRQ-1:0] pin_bit(input logic [PIN_W-1:0] p);
    logic [NUM_IRQ-1:0] v;
    v    = '0;
    v[p] = 1'b1;
    return v;
  endfunction

  logic [CNT_W-1:0]   cnt_q;
  logic [PIN_W-1:0]   pin_q;
  logic               spur_q;
  logic [DATA_W-1:0]  vec_q;
  logic [PIN_W-1:0]   sel_pin;
  logic               sel_spur;
  logic [PIN_W-1:0]   cur_pin;
  logic               cur_spur;
  logic [NUM_IRQ-1:0] clr_vec;
  logic [NUM_IRQ-1:0] set_vec;
  logic [NUM_IRQ-1:0] isr_d;

  assign commit   = inta && (cnt_q == '0);
  assign finish   = inta && (cnt_q == LAST);
  assign busy     = (cnt_q != '0);
  assign sel_spur = !cand_valid;
  assign sel_pin  = cand_valid ? cand_pin : SPUR_PIN;
  assign cur_pin  = commit ? sel_pin  : pin_q;
  assign cur_spur = commit ? sel_spur : spur_q;

  always_comb begin
    clr_vec = '0;
    if (eoi_ns) clr_vec = clr_vec | (isr_q & (~isr_q + NUM_IRQ'(1)));
    if (eoi_sp) clr_vec = clr_vec | pin_bit(eoi_pin);
    if (finish && aeoi && !cur_spur) clr_vec = clr_vec | pin_bit(cur_pin);
    set_vec = '0;
    if (commit && cand_valid) set_vec = pin_bit(cand_pin);
    isr_d = (isr_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pin_q  <= '0;
      spur_q <= 1'b0;
      vec_q  <= '0;
      isr_q  <= '0;
    end else begin
      isr_q <= isr_d;
      if (inta) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
      if (commit) begin
        pin_q  <= sel_pin;
        spur_q <= sel_spur;
        vec_q  <= make_vector(base, sel_pin);
      end
    end
  end

  assign vec    = commit ? make_vector(base, sel_pin) : vec_q;
  assign vec_oe = finish;
endmodule

// File: rtl/vpic_top.sv
`timescale 1ns/1ps
module vpic_top #(
  parameter int unsigned NUM_IRQ     = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ACK_STROBES = vpic_pkg::ACK_STROBES_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req_i,
  output logic               intr_o,
  input  logic               inta_i,
  input  logic               reg_wr_i,
  input  logic               reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic [DATA_W-1:0]  vec_o,
  output logic               vec_oe_o
);
  localparam int unsigned PIN_W  = $clog2(NUM_IRQ);
  localparam int unsigned BASE_W = DATA_W - PIN_W;

  logic [NUM_IRQ-1:0] irr_q;
  logic [NUM_IRQ-1:0] mask_q;
  logic [BASE_W-1:0]  base_q;
  logic               aeoi_q;
  logic               eoi_ns;
  logic               eoi_sp;
  logic               eoi_any;
  logic [PIN_W-1:0]   eoi_pin;
  logic [NUM_IRQ-1:0] isr_q;
  logic [NUM_IRQ-1:0] allow;
  logic               cand_valid;
  logic [PIN_W-1:0]   cand_pin;
  logic               ack_busy;
  logic               ack_commit;
  logic               ack_finish;

  always_ff @(posedge clk) begin
    if (!rst_n) irr_q <= '0;
    else        irr_q <= irq_req_i;
  end

  vpic_regs #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_i), .addr(reg_addr_i), .wdata(reg_wdata_i), .rdata(reg_rdata_o),
    .mask_q(mask_q), .base_q(base_q), .aeoi_q(aeoi_q),
    .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_pin(eoi_pin)
  );

  vpic_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
    .irr(irr_q), .mask(mask_q), .isr(isr_q),
    .allow(allow), .cand_valid(cand_valid), .cand_pin(cand_pin)
  );

  vpic_ack #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ACK_STROBES(ACK_STROBES)) u_ack (
    .clk(clk), .rst_n(rst_n), .inta(inta_i),
    .cand_valid(cand_valid), .cand_pin(cand_pin),
    .base(base_q), .aeoi(aeoi_q),
    .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_pin(eoi_pin),
    .isr_q(isr_q), .busy(ack_busy), .commit(ack_commit), .finish(ack_finish),
    .vec(vec_o), .vec_oe(vec_oe_o)
  );

  assign eoi_any = eoi_ns || eoi_sp;
  assign intr_o  = cand_valid && !ack_busy;
endmodule

// File: rtl/vpic_chk.sv
`timescale 1ns/1ps
module vpic_chk #(
  parameter int unsigned NUM_IRQ = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       inta_i,
  input logic                       intr_o,
  input logic                       vec_oe_o,
  input logic [NUM_IRQ-1:0]         irr_q,
  input logic [NUM_IRQ-1:0]         mask_q,
  input logic [NUM_IRQ-1:0]         isr_q,
  input logic                       cand_valid,
  input logic [$clog2(NUM_IRQ)-1:0] cand_pin,
  input logic                       ack_busy,
  input logic                       ack_commit,
  input logic                       ack_finish,
  input logic                       eoi_any
);
  localparam int unsigned PIN_W = $clog2(NUM_IRQ);

  function automatic logic [NUM_IRQ-1:0] upto(input logic [PIN_W-1:0] p);
    logic [NUM_IRQ-1:0] m;
    for (int i = 0; i < NUM_IRQ; i++) m[i] = (i <= int'(p));
    return m;
  endfunction

  // R5
  oe_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe_o |-> (inta_i && ack_finish));

  // R12
  no_intr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_busy |-> !intr_o);

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr_q & ~mask_q) == '0) |-> !intr_o);

  // R6
  commit_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_commit && cand_valid) |=> isr_q[$past(cand_pin)]);

  // R6
  intr_above_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intr_o |-> ((isr_q & upto(cand_pin)) == '0));

  // R11
  spurious_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_commit && !cand_valid && !eoi_any) |=> (isr_q == $past(isr_q)));
endmodule

bind vpic_top vpic_chk #(.NUM_IRQ(NUM_IRQ)) u_vpic_chk (
  .clk(clk), .rst_n(rst_n), .inta_i(inta_i), .intr_o(intr_o), .vec_oe_o(vec_oe_o),
  .irr_q(irr_q), .mask_q(mask_q), .isr_q(isr_q),
  .cand_valid(cand_valid), .cand_pin(cand_pin),
  .ack_busy(ack_busy), .ack_commit(ack_commit), .ack_finish(ack_finish),
  .eoi_any(eoi_any)
);

// File: tb/vpic_top_test.sv
`timescale 1ns/1ps
module vpic_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       inta = 1'b0;
  logic       wr = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       intr;
  logic [7:0] vec;
  logic       oe;
  int         n_chk = 0;
  int         n_fail = 0;
  logic [4:0] cur_base = '0;

  always #10 clk = ~clk;

  vpic_top uut (
    .clk(clk), .rst_n(rst_n), .irq_req_i(req), .intr_o(intr), .inta_i(inta),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .vec_o(vec), .vec_oe_o(oe)
  );

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrreg(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 1'b0;
  endtask

  function automatic int low_pin(input logic [7:0] p);
    for (int i = 7; i >= 0; i--) if (p[i]) low_pin = i;
  endfunction

  // three acknowledge cycles; vector expected as base*8+pin
  task automatic ack(input int pin, input string r);
    for (int c = 0; c < 3; c++) begin
      inta = 1'b1;
      #2;
      if (c == 2) begin
        chk({r, " R5 oe"}, {7'd0, oe}, 8'd1);
        chk({r, " R5 vec"}, vec, 8'(int'(cur_base) * 8 + pin));
      end else begin
        chk("R5 oe low", {7'd0, oe}, 8'd0);
      end
      if (c > 0) chk("R12 intr low in ack", {7'd0, intr}, 8'd0);
      @(negedge clk);
    end
    inta = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    // R1 reset state
    req = 8'hFF; cyc(1);
    chk("R1 intr", {7'd0, intr}, 8'd0);
    addr = 1'b1; #1 chk("R1 mask", rdata, 8'hFF);
    addr = 1'b0; #1 chk("R1 addr0", rdata, 8'h00);
    req = 8'h00; cyc(1);
    wrreg(1'b1, 8'h00);
    addr = 1'b1; #1 chk("R3 mask rd", rdata, 8'h00);
    addr = 1'b0;

    // R13 R2 R4 R6 R8 R10: every pin under two bases
    for (int bi = 0; bi < 2; bi++) begin
      cur_base = (bi == 0) ? 5'h1A : 5'h05;
      wrreg(1'b0, {3'b110, cur_base});
      for (int p = 0; p < 8; p++) begin
        req = 8'(1 << p); cyc(1);
        chk("R4 intr rise", {7'd0, intr}, 8'd1);
        ack(p, "R13");
        chk("R6 held blocked", {7'd0, intr}, 8'd0);
        wrreg(1'b0, 8'(8'h80 | p));
        chk("R10 reassert", {7'd0, intr}, 8'd1);
        req = 8'h00; cyc(1);
        chk("R4 intr fall", {7'd0, intr}, 8'd0);
      end
    end

    // R2 R7: every request pattern
    for (int pat = 1; pat < 256; pat++) begin
      req = 8'(pat); cyc(1);
      chk("R4 pattern intr", {7'd0, intr}, 8'd1);
      ack(low_pin(8'(pat)), "R2");
      wrreg(1'b0, 8'h40);
      chk("R7 ns eoi reassert", {7'd0, intr}, 8'd1);
      req = 8'h00; cyc(1);
    end

    // R3: every mask value
    for (int m = 0; m < 256; m++) begin
      wrreg(1'b1, 8'(m));
      req = 8'((m * 37 + 11) & 255); cyc(1);
      chk("R3 masked intr", {7'd0, intr}, {7'd0, |(req & ~8'(m))});
      addr = 1'b1; #1 chk("R3 readback", rdata, 8'(m));
      addr = 1'b0;
      req = 8'h00; cyc(1);
    end
    wrreg(1'b1, 8'h00);

    // R6 R7: blocking and non-specific clear of most urgent
    req = 8'h08; cyc(1); ack(3, "R6");
    req = 8'h28; cyc(1);
    chk("R6 lower blocked", {7'd0, intr}, 8'd0);
    req = 8'h2A; cyc(1);
    chk("R6 higher passes", {7'd0, intr}, 8'd1);
    ack(1, "R6");
    req = 8'h08;
    wrreg(1'b0, 8'h40);
    chk("R7 only bit1 cleared", {7'd0, intr}, 8'd0);
    wrreg(1'b0, 8'h83);
    chk("R8 bit3 cleared", {7'd0, intr}, 8'd1);
    req = 8'h00; cyc(1);

    // R8: specific clears only its own bit
    req = 8'h08; cyc(1); ack(3, "R8");
    req = 8'h0A; cyc(1); ack(1, "R8");
    wrreg(1'b0, 8'h83);
    chk("R8 bit1 still set", {7'd0, intr}, 8'd0);
    wrreg(1'b0, 8'h81);
    chk("R8 all clear", {7'd0, intr}, 8'd1);
    req = 8'h00; cyc(1);

    // R9 automatic end-of-interrupt
    wrreg(1'b0, 8'h01);
    req = 8'h10; cyc(1); ack(4, "R9");
    chk("R9 auto clear", {7'd0, intr}, 8'd1);
    req = 8'h00; cyc(1);
    wrreg(1'b0, 8'h00);
    req = 8'h10; cyc(1); ack(4, "R9");
    chk("R9 off keeps isr", {7'd0, intr}, 8'd0);
    wrreg(1'b0, 8'h40);
    req = 8'h00; cyc(1);

    // R11 spurious acknowledge
    req = 8'h20; cyc(1);
    chk("R11 intr up", {7'd0, intr}, 8'd1);
    req = 8'h00; cyc(1);
    chk("R11 intr gone", {7'd0, intr}, 8'd0);
    ack(7, "R11");
    req = 8'h80; cyc(1);
    chk("R11 no isr set", {7'd0, intr}, 8'd1);
    ack(7, "R11");
    wrreg(1'b0, 8'h40);
    req = 8'h00; cyc(1);
    chk("R4 idle", {7'd0, intr}, 8'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule